// File: doc/BRIEF.md
# Two-Thread Pipeline Stage Arbiter

This block decides, cycle by cycle, which of two hardware threads may push micro-ops into a shared pipeline stage of a simultaneous-multithreading core. A thread offers work with `req_valid` and a requested count. The arbiter answers in the same cycle with `grant_vld`, the thread number and the number of micro-ops taken. When both threads can proceed, the grant alternates. When only one can proceed, it gets every cycle. A thread that is stalled, halted, blocked on the miss pool or out of buffer room drops out of the choice.

The arbiter also keeps a count of each thread's entries in a reorder structure. This structure is split in half while both threads run. If one thread halts, the sole survivor may fill the whole structure. A pool of outstanding cache-miss slots is shared on a first-come basis. A request that finds the pool full is refused, and the requesting thread is held back until some slot frees.

Back-pressure: the grant is the ready side of each thread's request. A request not granted in a cycle is not consumed, and the thread simply presents it again. The grant, count, caps and miss accepts are combinational from the current state and inputs. The state moves on the rising clock edge.

Top module: `smt_stage_arbiter`

## Requirements
- R1: A synchronous active-high reset empties both occupancy counts and the miss pool, makes both threads active, clears all miss blocks and points the next contested grant at thread 0.
- R2: When both threads are eligible, the grant goes to the pointed thread. After any grant, the pointer moves to the other thread, so contested grants alternate every cycle.
- R3: When exactly one thread is eligible it is granted. When none is eligible, `grant_vld` is 0, `grant_cnt` is 0 and the pointer keeps its value.
- R4: A thread is eligible only if all of these hold:
  - it is active;
  - its `req_valid` bit is 1 and its requested count is nonzero;
  - its `stall_in` bit is 0;
  - it is not miss-blocked;
  - its occupancy is below its cap.
- R5: The accepted count is the minimum of the requested count, 4, and the granted thread's cap minus its occupancy. Each cycle, occupancy rises by the accepted count and falls by the retire count, where the retire count is clamped to the occupancy held before that edge.
- R6: The per-thread cap is 16 for each thread while both are active. It is 32 for a thread that is the only active one, and 0 for a halted thread.
- R7: A `halt_req` bit makes its thread inactive from the next cycle, and a `wake_req` bit makes it active; wake wins if both are set. After a wake, a thread whose occupancy is at or above its new cap stays ineligible until retirements bring it below.
- R8: The miss pool holds 10 entries shared by both threads. In one cycle thread 0's request is served first, then thread 1's if a slot remains. An accept is signalled on `miss_ack` in the same cycle.
- R9: A refused miss request blocks its thread from the next cycle until a cycle in which some completion frees an entry. A `miss_done` bit for a thread with no miss in flight is ignored.
- R10: Per-thread multi-bit inputs are packed in 3-bit lanes, with thread t at bits [3t+2:3t]. `cap_out` uses 6-bit lanes, with thread t at bits [6t+5:6t].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Thread has micro-ops to offer |
| req_cnt | input | 6 | Requested micro-op count per thread (3-bit lanes) |
| stall_in | input | 2 | External stall per thread |
| halt_req | input | 2 | Put thread to sleep |
| wake_req | input | 2 | Wake thread |
| retire_cnt | input | 6 | Entries retired per thread (3-bit lanes) |
| miss_req | input | 2 | New cache-miss request per thread |
| miss_done | input | 2 | Miss completion per thread |
| grant_vld | output | 1 | A thread is granted this cycle |
| grant_tid | output | 1 | Granted thread number |
| grant_cnt | output | 3 | Micro-ops accepted this cycle |
| cap_out | output | 12 | Occupancy cap per thread (6-bit lanes) |
| miss_ack | output | 2 | Miss request accepted |

## Verification
A wrong occupancy count first shows up as a wrong `grant_cnt` once a thread nears its cap, or as a grant given to a thread that should be full. That can surface many cycles after the fault itself. A wrong pointer shows on the very next contested cycle as a repeated thread number. A miss-pool count that drifts shows as an accept when the pool should be full, or as a refusal when it should not. The per-cycle reference comparison therefore runs long phases that saturate the buffer and the pool, so these delayed faults still surface.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;
  localparam int NTHR = 2;
  typedef logic [NTHR-1:0] tmask_t;
endpackage

// File: rtl/smt_grant_pick.sv
module smt_grant_pick
  import smt_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  tmask_t elig,
  output logic   gvld,
  output logic   gtid
);
  logic ptr_q;

  always_comb begin
    gvld = |elig;
    if (elig == 2'b11) gtid = ptr_q;
    else               gtid = elig[1];
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= 1'b0;
    else if (gvld) ptr_q <= ~gtid;
  end
endmodule

// File: rtl/smt_occ_track.sv
module smt_occ_track #(
  parameter int CAPW = 6,
  parameter int REQW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CAPW-1:0] cap,
  input  logic [REQW-1:0] add,
  input  logic [REQW-1:0] ret,
  output logic [CAPW-1:0] occ,
  output logic [CAPW-1:0] room
);
  logic [CAPW-1:0] ret_x, ret_eff, add_x;

  always_comb begin
    ret_x   = {{(CAPW-REQW){1'b0}}, ret};
    add_x   = {{(CAPW-REQW){1'b0}}, add};
    ret_eff = (ret_x > occ) ? occ : ret_x;
    room    = (occ < cap) ? (cap - occ) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ - ret_eff + add_x;
  end
endmodule

// File: rtl/smt_miss_pool.sv
module smt_miss_pool
  import smt_arb_pkg::*;
#(
  parameter int SLOTS = 10,
  localparam int SW = $clog2(SLOTS + 1) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  tmask_t        req,
  input  tmask_t        done,
  output tmask_t        ack,
  output tmask_t        blk,
  output logic [SW-1:0] busy
);
  logic [SW-1:0] inflt [NTHR];
  tmask_t        done_eff;
  logic          freed;

  always_comb begin
    busy     = inflt[0] + inflt[1];
    ack[0]   = req[0] && (busy < SW'(SLOTS));
    ack[1]   = req[1] && ((busy + SW'(ack[0])) < SW'(SLOTS));
    freed    = |done_eff;
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign done_eff[t] = done[t] && (inflt[t] != '0);
    always_ff @(posedge clk) begin
      if (rst) begin
        inflt[t] <= '0;
        blk[t]   <= 1'b0;
      end else begin
        inflt[t] <= inflt[t] - SW'(done_eff[t]) + SW'(ack[t]);
        blk[t]   <= (req[t] && !ack[t]) || (blk[t] && !freed);
      end
    end
  end
endmodule

// File: rtl/smt_stage_arbiter.sv
module smt_stage_arbiter
  import smt_arb_pkg::*;
#(
  parameter int CAP      = 32,
  parameter int MAX_UOPS = 4,
  parameter int SLOTS    = 10,
  parameter int REQW     = 3,
  localparam int CAPW    = $clog2(CAP + 1),
  localparam int SW      = $clog2(SLOTS + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           req_valid,
  input  logic [2*REQW-1:0]    req_cnt,
  input  logic [1:0]           stall_in,
  input  logic [1:0]           halt_req,
  input  logic [1:0]           wake_req,
  input  logic [2*REQW-1:0]    retire_cnt,
  input  logic [1:0]           miss_req,
  input  logic [1:0]           miss_done,
  output logic                 grant_vld,
  output logic                 grant_tid,
  output logic [REQW-1:0]      grant_cnt,
  output logic [2*CAPW-1:0]    cap_out,
  output logic [1:0]           miss_ack
);
  localparam logic [CAPW-1:0] FULLC = CAPW'(CAP);
  localparam logic [CAPW-1:0] HALFC = CAPW'(CAP / 2);
  localparam logic [REQW-1:0] MAXU  = REQW'(MAX_UOPS);

  tmask_t          active_q, elig, blk;
  logic [CAPW-1:0] cap  [NTHR];
  logic [CAPW-1:0] occ  [NTHR];
  logic [CAPW-1:0] room [NTHR];
  logic [REQW-1:0] add  [NTHR];
  logic [2*CAPW-1:0] occ_vec;
  logic [SW-1:0]   busy;
  logic [REQW-1:0] rq, rq_lim, room_lim;

  always_ff @(posedge clk) begin
    if (rst) active_q <= 2'b11;
    else     active_q <= wake_req | (active_q & ~halt_req);
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_lane
    always_comb begin
      if (!active_q[t])        cap[t] = '0;
      else if (&active_q)      cap[t] = HALFC;
      else                     cap[t] = FULLC;
      elig[t] = active_q[t] && req_valid[t] && (req_cnt[t*REQW +: REQW] != '0)
             && !stall_in[t] && !blk[t] && (occ[t] < cap[t]);
      add[t]  = (grant_vld && (grant_tid == t[0])) ? grant_cnt : '0;
    end
    assign cap_out[t*CAPW +: CAPW] = cap[t];
    assign occ_vec[t*CAPW +: CAPW] = occ[t];

    smt_occ_track #(.CAPW(CAPW), .REQW(REQW)) u_occ (
      .clk (clk),
      .rst (rst),
      .cap (cap[t]),
      .add (add[t]),
      .ret (retire_cnt[t*REQW +: REQW]),
      .occ (occ[t]),
      .room(room[t])
    );
  end

  smt_grant_pick u_pick (
    .clk (clk),
    .rst (rst),
    .elig(elig),
    .gvld(grant_vld),
    .gtid(grant_tid)
  );

  always_comb begin
    rq       = grant_tid ? req_cnt[REQW +: REQW] : req_cnt[0 +: REQW];
    rq_lim   = (rq > MAXU) ? MAXU : rq;
    room_lim = (room[grant_tid] > CAPW'(MAX_UOPS)) ? MAXU : room[grant_tid][REQW-1:0];
    if (!grant_vld)            grant_cnt = '0;
    else if (rq_lim < room_lim) grant_cnt = rq_lim;
    else                        grant_cnt = room_lim;
  end

  smt_miss_pool #(.SLOTS(SLOTS)) u_miss (
    .clk (clk),
    .rst (rst),
    .req (miss_req),
    .done(miss_done),
    .ack (miss_ack),
    .blk (blk),
    .busy(busy)
  );
endmodule

// File: rtl/smt_arb_chk.sv
module smt_arb_chk #(
  parameter int CAP = 32, MAX_UOPS = 4, SLOTS = 10, REQW = 3, CAPW = 6, SW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        elig,
  input logic [1:0]        active_q,
  input logic              grant_vld,
  input logic              grant_tid,
  input logic [REQW-1:0]   grant_cnt,
  input logic [2*CAPW-1:0] cap_out,
  input logic [2*CAPW-1:0] occ_vec,
  input logic [SW-1:0]     busy
);
  // R2
  alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && elig == 2'b11) |=> (elig != 2'b11 || grant_tid != $past(grant_tid)));
  // R4
  halted_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> active_q[grant_tid]);
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> (grant_cnt != '0 && grant_cnt <= REQW'(MAX_UOPS)));
  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ_vec[CAPW-1:0] <= CAPW'(CAP) && occ_vec[2*CAPW-1:CAPW] <= CAPW'(CAP));
  // R6
  solo_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q == 2'b01) |-> cap_out[CAPW-1:0] == CAPW'(CAP));
  // R8
  pool_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy <= SW'(SLOTS));
endmodule

bind smt_stage_arbiter smt_arb_chk #(
  .CAP(CAP), .MAX_UOPS(MAX_UOPS), .SLOTS(SLOTS), .REQW(REQW), .CAPW(CAPW), .SW(SW)
) u_chk (
  .clk(clk), .rst(rst), .elig(elig), .active_q(active_q), .grant_vld(grant_vld),
  .grant_tid(grant_tid), .grant_cnt(grant_cnt), .cap_out(cap_out),
  .occ_vec(occ_vec), .busy(busy)
);

// File: tb/sim_smt_stage_arbiter.sv
`timescale 1ns/1ps
module sim_smt_stage_arbiter;
  logic clk = 0, rst = 1;
  logic [1:0] req_valid = 0, stall_in = 0, halt_req = 0, wake_req = 0, miss_req = 0, miss_done = 0;
  logic [5:0] req_cnt = 0, retire_cnt = 0;
  logic grant_vld, grant_tid;
  logic [2:0] grant_cnt;
  logic [11:0] cap_out;
  logic [1:0] miss_ack;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int occ[2], act[2], minf[2], blk[2], ptr;

  always #2.5 clk = ~clk;

  smt_stage_arbiter u0 (.*);

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < 2; t++) begin occ[t] = 0; act[t] = 1; minf[t] = 0; blk[t] = 0; end
    ptr = 0;
  endtask

  // one cycle: inputs driven already; compare then advance model at the edge
  task automatic step();
    int cap[2], el[2], rc[2], rt[2], g, c, fr, a[2], d[2], fev, tot;
    #1;
    for (int t = 0; t < 2; t++) begin
      rc[t]  = int'(req_cnt[3*t +: 3]);
      rt[t]  = int'(retire_cnt[3*t +: 3]);
      cap[t] = act[t] == 0 ? 0 : ((act[0] == 1 && act[1] == 1) ? 16 : 32);
      el[t]  = (act[t] == 1 && req_valid[t] && rc[t] > 0 && !stall_in[t] && blk[t] == 0 && occ[t] < cap[t]) ? 1 : 0;
    end
    g = -1;
    if (el[0] == 1 && el[1] == 1) g = ptr;
    else if (el[0] == 1) g = 0;
    else if (el[1] == 1) g = 1;
    c = 0;
    if (g >= 0) begin
      c = rc[g] < 4 ? rc[g] : 4;
      if (cap[g] - occ[g] < c) c = cap[g] - occ[g];
    end
    tot = minf[0] + minf[1];
    a[0] = (miss_req[0] && tot < 10) ? 1 : 0;
    a[1] = (miss_req[1] && tot + a[0] < 10) ? 1 : 0;
    chk("R2 R3 R4 grant_vld", int'(grant_vld), g >= 0 ? 1 : 0);
    if (g >= 0) chk("R2 R3 grant_tid", int'(grant_tid), g);
    chk("R5 R10 grant_cnt", int'(grant_cnt), c);
    chk("R6 R7 cap0", int'(cap_out[5:0]), cap[0]);
    chk("R6 R7 cap1", int'(cap_out[11:6]), cap[1]);
    chk("R8 R9 miss_ack", int'(miss_ack), a[0] + 2 * a[1]);
    @(posedge clk);
    fev = 0;
    for (int t = 0; t < 2; t++) begin
      d[t] = (miss_done[t] && minf[t] > 0) ? 1 : 0;
      if (d[t] == 1) fev = 1;
    end
    for (int t = 0; t < 2; t++) begin
      occ[t]  = occ[t] - (rt[t] < occ[t] ? rt[t] : occ[t]) + (g == t ? c : 0);
      minf[t] = minf[t] - d[t] + a[t];
      blk[t]  = ((miss_req[t] && a[t] == 0) || (blk[t] == 1 && fev == 0)) ? 1 : 0;
      if (wake_req[t]) act[t] = 1; else if (halt_req[t]) act[t] = 0;
    end
    if (g >= 0) ptr = 1 - g;
    @(negedge clk);
  endtask

  function automatic logic pick(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: after reset both active, contested grant goes to thread 0
    req_valid = 2'b11; req_cnt = {3'd2, 3'd7};
    #1;
    chk("R1 first grant tid", int'(grant_tid), 0);
    chk("R1 first grant cnt", int'(grant_cnt), 4);
    chk("R1 cap split", int'(cap_out), 16 + 64 * 16);
    #0; @(negedge clk); #0;
    // undo the +1 delay: restart aligned
    rst = 1; @(negedge clk); @(negedge clk); rst = 0; model_reset();
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 2500; i++) begin
        for (int t = 0; t < 2; t++) begin
          req_valid[t] = pick(ph == 0 ? 95 : 70);
          req_cnt[3*t +: 3] = 3'($urandom);
          stall_in[t] = pick(ph == 0 ? 0 : 25);
          halt_req[t] = pick(ph >= 2 ? 3 : 0);
          wake_req[t] = pick(ph >= 2 ? 4 : (ph == 1 ? 2 : 0));
          retire_cnt[3*t +: 3] = pick(ph == 0 ? 20 : (ph == 2 ? 80 : 40)) ? 3'($urandom) : 3'd0;
          miss_req[t] = pick(ph == 1 ? 60 : 15);
          miss_done[t] = pick(ph == 1 ? 5 : 30);
        end
        step();
      end
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule